// File: doc/BRIEF.md
# Signaling Change-of-State Detector

This block follows the per-channel signaling nibbles (the four A/B/C/D bits) of a framed 24- or 32-channel trunk and tells the host which channels changed their signaling state. Upstream logic recovers the framing and extracts the bits. It hands each channel's latest nibble to the block as an index plus a value. It also pulses a strobe at every multiframe boundary. The block stages the incoming values. It commits them to a per-channel state register only on that boundary strobe, so the committed state is always a multiframe-aligned snapshot.

On each boundary, a channel whose new value differs from its committed state reports a change. When the global integration input is high, a channel reports only after the new value has been seen unchanged on three consecutive boundaries. This filters out glitches on the line. Every reported change sets that channel's sticky status bit. Only channels selected by the host's per-channel mask can set the sticky summary latch. The summary drives an active-low interrupt when the interrupt mask allows it. The host clears status and summary bits by writing ones. It can read any channel's committed state through an index port.

The first boundary after reset only loads the committed states and reports nothing.

Top module: `sig_cos_detect`

## Requirements
- R1: A channel's committed state (seen on `rdState`) changes only in the clock cycle after a cycle with `mfStrobe` high. Writes through `chWe` alone leave it unchanged.
- R2: On the first `mfStrobe` after reset, every channel's committed state takes its staged value. No status bit and no summary bit is set.
- R3: With `integEn` low, on each later `mfStrobe`, a channel whose staged value differs from its committed state takes the staged value and sets its bit in `stsBits`. A channel whose staged value matches changes nothing.
- R4: With `integEn` high, a channel reports a change (state update plus status bit) only on the third consecutive `mfStrobe` at which the same new value is staged. Any different value on a boundary in between restarts the count from one.
- R5: `integEn` is a single input that applies to all channels at once. Several channels that change on the same boundary are each filtered independently.
- R6: `stsBits[i]` is set by every reported change on channel i, whatever `selMask[i]` is.
- R7: `summary` is set on a boundary where some channel i with `selMask[i]`=1 reports a change. A change on a channel with `selMask[i]`=0 does not set it.
- R8: `irqN` is 0 exactly when `summary` is 1 and `irqMask` is 1, and is 1 otherwise.
- R9: Status bits are sticky. `stsClr[i]`=1 clears `stsBits[i]` on the next edge, but a change reported on channel i in the same cycle leaves the bit set.
- R10: `summary` is sticky. `sumClr`=1 clears it, but a qualifying change in the same cycle leaves it set.
- R11: `rdState` shows, without a clock delay, the committed state of the channel selected by `rdIdx`.
- R12: After reset, all committed states are 0, `stsBits` is 0, `summary` is 0 and `irqN` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mfStrobe | input | 1 | One-cycle multiframe boundary pulse |
| chWe | input | 1 | Stage `chVal` for channel `chIdx` |
| chIdx | input | CH_IDX_W | Channel being staged |
| chVal | input | NIB_W | Signaling nibble for that channel |
| integEn | input | 1 | Global three-multiframe integration enable |
| selMask | input | NUM_CH | Channels allowed to set the summary |
| irqMask | input | 1 | Lets the summary drive the interrupt |
| stsClr | input | NUM_CH | Write-one-to-clear for the status bits |
| sumClr | input | 1 | Write-one-to-clear for the summary |
| rdIdx | input | CH_IDX_W | Channel selected for state readback |
| rdState | output | NIB_W | Committed state of channel `rdIdx` |
| stsBits | output | NUM_CH | Sticky per-channel change status |
| summary | output | 1 | Sticky summary of selected changes |
| irqN | output | 1 | Active-low interrupt |

## Verification
Some properties are checked on every cycle:
- committed state and status bits never move without a boundary strobe;
- the first boundary sets no status;
- status and summary bits hold unless cleared;
- the summary rises only from a boundary;
- the interrupt is low only while both the summary and the mask are set.

Other behaviour needs the bench's scenarios, which compare against a model built from the requirements:
- the three-boundary integration count and its restart;
- which channels set status versus summary under the select mask;
- event-beats-clear races;
- the exact committed values across sweeps of nibble patterns.

// File: rtl/sig_cos_pkg.sv
package sig_cos_pkg;

  // Strobes from control to datapath, valid in the boundary cycle.
  typedef struct packed {
    logic eval;   // multiframe boundary: evaluate all channels
    logic prime;  // first boundary since reset: load without reporting
    logic integ;  // integration filter active for this boundary
  } cosStb_t;

endpackage

// File: rtl/sig_cos_ctrl.sv
module sig_cos_ctrl
  import sig_cos_pkg::*;
#(
  parameter int NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mfStrobe,
  input  logic              integEn,
  input  logic [NUM_CH-1:0] eventVec,
  input  logic [NUM_CH-1:0] selMask,
  input  logic              sumClr,
  input  logic              irqMask,
  output cosStb_t           stb,
  output logic              summary,
  output logic              irqN
);

  logic primedQ;
  logic sumQ;
  logic selHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primedQ <= 1'b0;
    end else if (mfStrobe) begin
      primedQ <= 1'b1;
    end
  end

  always_comb begin
    stb.eval  = mfStrobe;
    stb.prime = mfStrobe && !primedQ;
    stb.integ = integEn;
  end

  assign selHit = |(eventVec & selMask);

  // Sticky summary: a new qualifying event wins over a clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumQ <= 1'b0;
    end else begin
      sumQ <= (sumQ && !sumClr) || selHit;
    end
  end

  assign summary = sumQ;
  assign irqN    = !(sumQ && irqMask);

endmodule

// File: rtl/sig_cos_datapath.sv
module sig_cos_datapath
  import sig_cos_pkg::*;
#(
  parameter int NUM_CH    = 32,
  parameter int NIB_W     = 4,
  parameter int STABLE_MF = 3,
  localparam int CH_IDX_W = $clog2(NUM_CH),
  localparam int CNT_W    = $clog2(STABLE_MF + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  cosStb_t             stb,
  input  logic                chWe,
  input  logic [CH_IDX_W-1:0] chIdx,
  input  logic [NIB_W-1:0]    chVal,
  input  logic [NUM_CH-1:0]   stsClr,
  input  logic [CH_IDX_W-1:0] rdIdx,
  output logic [NUM_CH-1:0]   eventVec,
  output logic [NUM_CH-1:0]   stsBits,
  output logic [NIB_W-1:0]    rdState
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(STABLE_MF);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [NIB_W-1:0] curArr [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    logic [NIB_W-1:0] stageQ;
    logic [NIB_W-1:0] curQ;
    logic [NIB_W-1:0] candQ;
    logic [CNT_W-1:0] cntQ;
    logic [CNT_W-1:0] cntNext;
    logic             stsQ;
    logic             diffCur;
    logic             chEvent;

    // Consecutive boundaries on which the staged value has been the same.
    assign cntNext = (stageQ != candQ) ? CNT_ONE :
                     (cntQ >= CNT_FULL) ? CNT_FULL : cntQ + CNT_ONE;
    assign diffCur = (stageQ != curQ);
    assign chEvent = stb.eval && !stb.prime && diffCur &&
                     (!stb.integ || (cntNext == CNT_FULL));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stageQ <= '0;
        curQ   <= '0;
        candQ  <= '0;
        cntQ   <= '0;
        stsQ   <= 1'b0;
      end else begin
        if (chWe && (chIdx == CH_IDX_W'(g))) begin
          stageQ <= chVal;
        end
        if (stb.eval) begin
          candQ <= stageQ;
          cntQ  <= stb.prime ? CNT_ONE : cntNext;
          if (stb.prime || chEvent) begin
            curQ <= stageQ;
          end
        end
        stsQ <= (stsQ && !stsClr[g]) || chEvent;
      end
    end

    assign eventVec[g] = chEvent;
    assign stsBits[g]  = stsQ;
    assign curArr[g]   = curQ;
  end

  always_comb begin
    rdState = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rdIdx == CH_IDX_W'(i)) begin
        rdState = curArr[i];
      end
    end
  end

endmodule

// File: rtl/sig_cos_detect.sv
module sig_cos_detect
  import sig_cos_pkg::*;
#(
  parameter int NUM_CH    = 32,
  parameter int NIB_W     = 4,
  parameter int STABLE_MF = 3,
  localparam int CH_IDX_W = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                mfStrobe,
  input  logic                chWe,
  input  logic [CH_IDX_W-1:0] chIdx,
  input  logic [NIB_W-1:0]    chVal,
  input  logic                integEn,
  input  logic [NUM_CH-1:0]   selMask,
  input  logic                irqMask,
  input  logic [NUM_CH-1:0]   stsClr,
  input  logic                sumClr,
  input  logic [CH_IDX_W-1:0] rdIdx,
  output logic [NIB_W-1:0]    rdState,
  output logic [NUM_CH-1:0]   stsBits,
  output logic                summary,
  output logic                irqN
);

  cosStb_t           stb;
  logic [NUM_CH-1:0] eventVec;

  sig_cos_ctrl #(
    .NUM_CH(NUM_CH)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .mfStrobe(mfStrobe),
    .integEn (integEn),
    .eventVec(eventVec),
    .selMask (selMask),
    .sumClr  (sumClr),
    .irqMask (irqMask),
    .stb     (stb),
    .summary (summary),
    .irqN    (irqN)
  );

  sig_cos_datapath #(
    .NUM_CH   (NUM_CH),
    .NIB_W    (NIB_W),
    .STABLE_MF(STABLE_MF)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .chWe    (chWe),
    .chIdx   (chIdx),
    .chVal   (chVal),
    .stsClr  (stsClr),
    .rdIdx   (rdIdx),
    .eventVec(eventVec),
    .stsBits (stsBits),
    .rdState (rdState)
  );

endmodule

// File: rtl/sig_cos_chk.sv
module sig_cos_chk #(
  parameter int NUM_CH = 32,
  parameter int NIB_W  = 4,
  localparam int CH_IDX_W = $clog2(NUM_CH)
) (
  input logic                clk,
  input logic                rstN,
  input logic                mfStrobe,
  input logic [NUM_CH-1:0]   stsClr,
  input logic                sumClr,
  input logic                irqMask,
  input logic [CH_IDX_W-1:0] rdIdx,
  input logic [NIB_W-1:0]    rdState,
  input logic [NUM_CH-1:0]   stsBits,
  input logic                summary,
  input logic                irqN
);

  logic sawStb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sawStb <= 1'b0;
    end else if (mfStrobe) begin
      sawStb <= 1'b1;
    end
  end

  // R1
  state_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !mfStrobe |=> ($stable(rdIdx) -> $stable(rdState)));

  // R2
  prime_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mfStrobe && !sawStb) |=> (stsBits == '0));

  // R3
  sts_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    !mfStrobe |=> ((stsBits & ~$past(stsBits)) == '0));

  // R9
  sts_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(stsBits) & ~$past(stsClr)) & ~stsBits) == '0));

  // R7
  sum_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(summary) |-> $past(mfStrobe));

  // R10
  sum_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (summary && !sumClr) |=> summary);

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irqN |-> (irqMask && summary));

endmodule

bind sig_cos_detect sig_cos_chk #(
  .NUM_CH(NUM_CH),
  .NIB_W (NIB_W)
) uChk (.*);

// File: tb/sim_sig_cos_detect.sv
`timescale 1ns/1ps
module sim_sig_cos_detect;

  localparam int NCH = 8;
  localparam int IW  = $clog2(NCH);
  localparam int STB = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mfStrobe = 1'b0, chWe = 1'b0, integEn = 1'b0, irqMask = 1'b0, sumClr = 1'b0;
  logic [IW-1:0] chIdx = '0, rdIdx = '0;
  logic [3:0] chVal = '0;
  logic [NCH-1:0] selMask = '0, stsClr = '0;
  logic [3:0] rdState;
  logic [NCH-1:0] stsBits;
  logic summary, irqN;

  int checks = 0, failures = 0;
  bit done = 0;

  // Requirement-level model
  int mStage [NCH], mCur [NCH], mCand [NCH], mCnt [NCH];
  bit mPrimed = 0;
  logic [NCH-1:0] mSts = '0;
  bit mSum = 0;

  always #2.5 clk = ~clk;

  sig_cos_detect #(.NUM_CH(NCH), .NIB_W(4), .STABLE_MF(STB)) u0 (
    .clk(clk), .rstN(rstN), .mfStrobe(mfStrobe), .chWe(chWe), .chIdx(chIdx),
    .chVal(chVal), .integEn(integEn), .selMask(selMask), .irqMask(irqMask),
    .stsClr(stsClr), .sumClr(sumClr), .rdIdx(rdIdx), .rdState(rdState),
    .stsBits(stsBits), .summary(summary), .irqN(irqN)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic stage(input int ch, input int v);
    chWe = 1'b1; chIdx = IW'(ch); chVal = 4'(v);
    @(negedge clk);
    chWe = 1'b0;
    mStage[ch] = v;
  endtask

  task automatic boundary(input logic [NCH-1:0] clr, input bit sClr);
    logic [NCH-1:0] ev;
    ev = '0;
    for (int i = 0; i < NCH; i++) begin
      int n;
      n = (mStage[i] != mCand[i]) ? 1 : ((mCnt[i] >= STB) ? STB : mCnt[i] + 1);
      if (!mPrimed) begin
        mCur[i] = mStage[i];
        n = 1;
      end else if (mStage[i] != mCur[i] && (!integEn || n == STB)) begin
        ev[i] = 1'b1;
        mCur[i] = mStage[i];
      end
      mCand[i] = mStage[i];
      mCnt[i] = n;
    end
    mPrimed = 1;
    mSts = (mSts & ~clr) | ev;
    mSum = (mSum && !sClr) || (|(ev & selMask));
    mfStrobe = 1'b1; stsClr = clr; sumClr = sClr;
    @(negedge clk);
    mfStrobe = 1'b0; stsClr = '0; sumClr = 1'b0;
  endtask

  task automatic checkAll(input string tag);
    chk(stsBits == mSts, {tag, " stsBits"}, int'(stsBits), int'(mSts));
    chk(summary == mSum, {tag, " summary"}, int'(summary), int'(mSum));
    chk(irqN == !(mSum && irqMask), {tag, " R8 irqN"}, int'(irqN), int'(!(mSum && irqMask)));
    for (int ch = 0; ch < NCH; ch++) begin
      rdIdx = IW'(ch);
      @(negedge clk);
      chk(rdState == 4'(mCur[ch]), {tag, " R11 rdState"}, int'(rdState), mCur[ch]);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NCH; i++) begin
      mStage[i] = 0; mCur[i] = 0; mCand[i] = 0; mCnt[i] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R12 reset state
    checkAll("R12");

    // R2 priming: load states, no report
    for (int ch = 0; ch < NCH; ch++) stage(ch, ch + 3);
    selMask = '1; irqMask = 1'b1;
    boundary('0, 1'b0);
    chk(stsBits == '0, "R2 no status on first boundary", int'(stsBits), 0);
    chk(summary == 1'b0, "R2 no summary on first boundary", int'(summary), 0);
    checkAll("R2");

    // R1 staging without boundary leaves committed state
    stage(1, 4'hE);
    rdIdx = 1;
    @(negedge clk);
    chk(rdState == 4'd4, "R1 state held without boundary", int'(rdState), 4);
    checkAll("R1");

    // R3/R6/R7/R9 sweep with integration off
    integEn = 1'b0;
    for (int v = 0; v < 16; v++) begin
      selMask = v[0] ? 8'h0F : 8'hA0;
      irqMask = v[1];
      for (int ch = 0; ch < NCH; ch++)
        if (((v + ch) & 1) == 0) stage(ch, (v * 7 + ch * 3 + (ch & v)) & 15);
      boundary(v[2] ? '1 : '0, v[3]);
      checkAll("R3 R6 R7 R9 R10 sweep");
    end

    // R6/R7 directed: unselected channel sets status only
    boundary('1, 1'b1);
    selMask = 8'h00; irqMask = 1'b1;
    stage(0, (mCur[0] + 1) & 15);
    boundary('0, 1'b0);
    chk(stsBits[0] == 1'b1, "R6 status despite mask", int'(stsBits[0]), 1);
    chk(summary == 1'b0, "R7 unselected no summary", int'(summary), 0);
    chk(irqN == 1'b1, "R8 irq idle", int'(irqN), 1);
    selMask = 8'h01;
    stage(0, (mCur[0] + 1) & 15);
    boundary('0, 1'b0);
    chk(summary == 1'b1, "R7 selected sets summary", int'(summary), 1);
    chk(irqN == 1'b0, "R8 irq asserted", int'(irqN), 0);
    irqMask = 1'b0;
    @(negedge clk);
    chk(irqN == 1'b1, "R8 irq masked", int'(irqN), 1);

    // R9/R10 event beats clear in the same cycle
    stage(3, (mCur[3] + 5) & 15);
    selMask = 8'h08;
    boundary('1, 1'b1);
    chk(stsBits == 8'h08, "R9 event wins over clear", int'(stsBits), 8);
    chk(summary == 1'b1, "R10 event wins over clear", int'(summary), 1);
    boundary('1, 1'b1);
    chk(stsBits == 8'h00, "R9 clear", int'(stsBits), 0);
    chk(summary == 1'b0, "R10 clear", int'(summary), 0);

    // R4 directed: three boundaries, restart on interruption
    integEn = 1'b1; selMask = '1; irqMask = 1'b1;
    begin
      int oldV, newV;
      oldV = mCur[5]; newV = (oldV + 9) & 15;
      stage(5, newV);
      boundary('0, 1'b0);
      boundary('0, 1'b0);
      chk(stsBits[5] == 1'b0, "R4 no report after two", int'(stsBits[5]), 0);
      rdIdx = 5; @(negedge clk);
      chk(rdState == 4'(oldV), "R4 state held after two", int'(rdState), oldV);
      stage(5, (newV + 1) & 15);
      boundary('0, 1'b0);
      stage(5, newV);
      boundary('0, 1'b0);
      boundary('0, 1'b0);
      chk(stsBits[5] == 1'b0, "R4 restart after interruption", int'(stsBits[5]), 0);
      boundary('0, 1'b0);
      chk(stsBits[5] == 1'b1, "R4 reported on third", int'(stsBits[5]), 1);
      rdIdx = 5; @(negedge clk);
      chk(rdState == 4'(newV), "R4 new state committed", int'(rdState), newV);
      checkAll("R4");
    end

    // R4/R5 sweep: channels with differing hold lengths, all filtered
    for (int r = 0; r < 14; r++) begin
      for (int ch = 0; ch < NCH; ch++)
        stage(ch, ((r / (1 + ch % 4)) * 5 + ch) & 15);
      boundary(r[0] ? '1 : '0, r[1]);
      checkAll("R4 R5 integration sweep");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule